// File: doc/BRIEF.md
# Asynchronous Serial Receiver

This block recovers characters from an idle-high asynchronous serial line. An external divider supplies a one-cycle oversample tick at sixteen times the bit rate (the rate is a parameter). The receiver watches for a falling edge and confirms it as a start bit by voting near the bit's centre. It then collects the configured number of data bits, least significant first, optionally checks a parity bit, and samples the first stop bit. The character and its error flags are then placed in a single holding register.

The host sets the frame format on three inputs. The format is captured when a start bit is detected, so changing it during a frame has no effect on that frame. A one-cycle read strobe tells the block that the held character has been consumed. The strobe clears the completion and error flags and leaves the data visible. A later character overwrites an unread one.

Top module: `async_serial_rx`

## Requirements
- R1: After synchronous reset, `rx_full`, `frame_err` and `parity_err` are 0 and `rx_data` is all zeros.
- R2: `data_len` selects the data width: codes 0 to 4 give 5 to 9 bits, and codes 5 to 7 also give 9 bits. Bits arrive least significant first after one start bit (0). They are presented right-aligned in `rx_data`, and the unused upper bits read 0.
- R3: `par_mode` 2'b10 adds an even parity bit after the data, and 2'b11 adds an odd one. With 2'b00 or 2'b01 no parity bit is expected and `parity_err` stays 0. `parity_err` is 1 when the received parity bit differs from the one the selected mode computes over the data bits.
- R4: `frame_err` is 1 exactly when the first stop bit is decided as 0.
- R5: `two_stop` has no effect on reception. Completion happens at the first stop bit in either setting, and a start bit that directly follows the first stop bit is received as a new frame without a framing error.
- R6: Each bit spans 16 ticks, numbered 0 to 15 from the tick that first sees the start edge. `rx_full` rises in the clock cycle after tick 9 of the first stop bit.
- R7: A read strobe clears `rx_full`, `frame_err` and `parity_err` on the next cycle and leaves `rx_data` unchanged. If a character completes in the same cycle as the strobe, the new character wins.
- R8: Every bit is decided by a majority of three samples taken at ticks 7, 8 and 9, so a single disagreeing sample is outvoted.
- R9: A start edge whose vote at ticks 7 to 9 is high is treated as noise. Reception is abandoned and nothing completes.
- R10: While `rx_en` is 0 no frame starts, and dropping it during a frame abandons that frame. A character already held stays held.
- R11: A character that completes while an earlier one is unread replaces its data and both error flags.
- R12: Changes to `data_len`, `par_mode` or `two_stop` after a start bit is detected do not affect that frame.
- R13: `rx_data` changes only when a character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| data_len | input | 3 | Data width code (0..4 = 5..9 bits, 5..7 = 9 bits) |
| par_mode | input | 2 | 0x none, 10 even, 11 odd |
| two_stop | input | 1 | Stop count setting for the link; does not alter reception |
| os_tick | input | 1 | One-cycle oversample tick, 16 per bit |
| rd_stb | input | 1 | Read strobe for the held character |
| rx_data | output | 9 | Held character, right-aligned |
| rx_full | output | 1 | A character is held and unread |
| frame_err | output | 1 | Held character had a low first stop bit |
| parity_err | output | 1 | Held character failed its parity check |

## Verification
Assertions check several properties on every cycle. A read without a coinciding completion clears all flags. An error flag never shows without `rx_full`. `rx_data` moves only on completion. The captured format is frozen while a frame is in flight, and a disabled receiver is idle. Two things can only be shown by the bench scenarios: the recovered data values under voting and noise, and the exact cycle at which a frame completes. The bench covers parity in both senses, framing errors, a start bit directly after the first stop bit with two stop bits configured, and overwrite of an unread character. It compares every cycle against a model driven by the same tick stream.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int MIN_BITS = 5;
    localparam int MAX_BITS = 9;
    localparam int LEN_W    = $clog2(MAX_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Frame format captured when a start edge is accepted
    typedef struct packed {
        logic [LEN_W-1:0] last_idx;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } rx_cfg_t;

    // One completed character with its error status
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                frame_bad;
        logic                par_bad;
    } rx_char_t;

    function automatic rx_cfg_t decode_cfg(input logic [2:0] len_code,
                                           input logic [1:0] pmode,
                                           input logic       stop2);
        rx_cfg_t c;
        if (int'(len_code) > MAX_BITS - MIN_BITS)
            c.last_idx = LEN_W'(MAX_BITS - 1);
        else
            c.last_idx = LEN_W'(MIN_BITS - 1 + int'(len_code));
        c.par_en   = pmode[1];
        c.par_odd  = pmode[0];
        c.two_stop = stop2;
        return c;
    endfunction

    // Two earlier samples already counted, third sample live
    function automatic logic majority3(input logic [1:0] early, input logic last);
        return ({1'b0, early} + {2'b00, last}) >= 3'd2;
    endfunction

endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rxs_bit_timer.sv
module rxs_bit_timer import rxs_pkg::*; #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic launch,
    input  logic run,
    input  logic line,
    output logic decide,
    output logic bit_val,
    output logic bit_end
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] S_EARLY  = CW'(MID - 1);
    localparam logic [CW-1:0] S_CENTRE = CW'(MID);
    localparam logic [CW-1:0] S_LATE   = CW'(MID + 1);
    localparam logic [CW-1:0] S_LAST   = CW'(OSR - 1);

    logic [CW-1:0] phase;
    logic [1:0]    votes;

    always_ff @(posedge clk) begin
        if (rst || (!run && !launch)) begin
            phase <= '0;
            votes <= '0;
        end else if (launch) begin
            // the launching tick is slot 0 of the start bit
            phase <= CW'(1);
            votes <= '0;
        end else if (tick) begin
            if (phase == S_LAST) begin
                phase <= '0;
                votes <= '0;
            end else begin
                phase <= phase + 1'b1;
                if (phase == S_EARLY || phase == S_CENTRE)
                    votes <= votes + {1'b0, line};
            end
        end
    end

    assign decide  = run && tick && (phase == S_LATE);
    assign bit_end = run && tick && (phase == S_LAST);
    assign bit_val = majority3(votes, line);

    // R8
    votes_cap_chk: assert property (@(posedge clk) disable iff (rst)
        votes <= 2'd2);

endmodule

// File: rtl/rxs_frame.sv
module rxs_frame import rxs_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       tick,
    input  logic       line,
    input  logic [2:0] len_code,
    input  logic [1:0] pmode,
    input  logic       stop2,
    input  logic       decide,
    input  logic       bit_val,
    input  logic       bit_end,
    output logic       launch,
    output logic       busy,
    output logic       done,
    output rx_char_t   char_o
);
    rx_state_e           state;
    rx_cfg_t             cfg;
    logic [LEN_W-1:0]    idx;
    logic [MAX_BITS-1:0] shreg;
    logic                par_acc;
    logic                par_bad;

    assign launch = rx_en && (state == ST_IDLE) && tick && !line;
    assign busy   = (state != ST_IDLE);
    assign done   = rx_en && (state == ST_STOP) && decide;
    assign char_o = '{data: shreg, frame_bad: ~bit_val, par_bad: par_bad};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
        end else if (!rx_en) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state   <= ST_START;
                        cfg     <= decode_cfg(len_code, pmode, stop2);
                        idx     <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        par_bad <= 1'b0;
                    end
                end
                ST_START: begin
                    if (decide && bit_val) state <= ST_IDLE;
                    else if (bit_end)      state <= ST_DATA;
                end
                ST_DATA: begin
                    if (decide) begin
                        shreg[idx] <= bit_val;
                        par_acc    <= par_acc ^ bit_val;
                    end
                    if (bit_end) begin
                        if (idx == cfg.last_idx)
                            state <= cfg.par_en ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (decide)  par_bad <= (bit_val != (par_acc ^ cfg.par_odd));
                    if (bit_end) state   <= ST_STOP;
                end
                ST_STOP: begin
                    // only the first stop bit is examined
                    if (decide) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> state == ST_IDLE);

    // R12
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

    // R3
    parity_none_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg.par_en) |-> !char_o.par_bad);

    // R5
    first_stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cfg.two_stop) |=> !busy);

endmodule

// File: rtl/rxs_hold.sv
module rxs_hold import rxs_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  rx_char_t            char_i,
    input  logic                rd_stb,
    output logic [MAX_BITS-1:0] data_q,
    output logic                full_q,
    output logic                ferr_q,
    output logic                perr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            ferr_q <= 1'b0;
            perr_q <= 1'b0;
        end else if (done) begin
            data_q <= char_i.data;
            full_q <= 1'b1;
            ferr_q <= char_i.frame_bad;
            perr_q <= char_i.par_bad;
        end else if (rd_stb) begin
            full_q <= 1'b0;
            ferr_q <= 1'b0;
            perr_q <= 1'b0;
        end
    end

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !done) |=> (!full_q && !ferr_q && !perr_q));

    // R13
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(data_q));

    // R4
    err_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        (ferr_q || perr_q) |-> full_q);

endmodule

// File: rtl/async_serial_rx.sv
module async_serial_rx import rxs_pkg::*; #(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       serial_in,
    input  logic       rx_en,
    input  logic [2:0] data_len,
    input  logic [1:0] par_mode,
    input  logic       two_stop,
    input  logic       os_tick,
    input  logic       rd_stb,
    output logic [8:0] rx_data,
    output logic       rx_full,
    output logic       frame_err,
    output logic       parity_err
);
    logic     line;
    logic     launch, busy, done;
    logic     decide, bit_val, bit_end;
    rx_char_t char_w;

    rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (serial_in),
        .dout (line)
    );

    rxs_bit_timer #(.OSR(OSR)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .launch  (launch),
        .run     (busy),
        .line    (line),
        .decide  (decide),
        .bit_val (bit_val),
        .bit_end (bit_end)
    );

    rxs_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .tick     (os_tick),
        .line     (line),
        .len_code (data_len),
        .pmode    (par_mode),
        .stop2    (two_stop),
        .decide   (decide),
        .bit_val  (bit_val),
        .bit_end  (bit_end),
        .launch   (launch),
        .busy     (busy),
        .done     (done),
        .char_o   (char_w)
    );

    rxs_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .done   (done),
        .char_i (char_w),
        .rd_stb (rd_stb),
        .data_q (rx_data),
        .full_q (rx_full),
        .ferr_q (frame_err),
        .perr_q (parity_err)
    );

    // R6
    done_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_full);

endmodule

// File: tb/async_serial_rx_bench.sv
module async_serial_rx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_in = 1'b1;
    logic       rx_en = 1'b0;
    logic [2:0] data_len = 3'd3;
    logic [1:0] par_mode = 2'd0;
    logic       two_stop = 1'b0;
    logic       os_tick = 1'b0;
    logic       rd_stb = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, frame_err, parity_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference state, updated right after the edge on which the block changes
    logic [8:0] exp_data = '0;
    logic       exp_full = 1'b0;
    logic       exp_fe   = 1'b0;
    logic       exp_pe   = 1'b0;

    always #2 clk = ~clk;

    async_serial_rx u_async_serial_rx (
        .clk        (clk),
        .rst        (rst),
        .serial_in  (serial_in),
        .rx_en      (rx_en),
        .data_len   (data_len),
        .par_mode   (par_mode),
        .two_stop   (two_stop),
        .os_tick    (os_tick),
        .rd_stb     (rd_stb),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .frame_err  (frame_err),
        .parity_err (parity_err)
    );

    // tick generator: high for one cycle out of four
    int tdiv = 0;
    initial forever begin
        @(posedge clk);
        #1;
        tdiv    = (tdiv + 1) % 4;
        os_tick = (tdiv == 0);
    end

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // every-cycle comparison against the reference state
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R6 cycle rx_full", int'(rx_full), int'(exp_full));
            chk("R2 cycle rx_data", int'(rx_data), int'(exp_data));
            chk("R4 cycle frame_err", int'(frame_err), int'(exp_fe));
            chk("R3 cycle parity_err", int'(parity_err), int'(exp_pe));
        end
    end

    task automatic wait_tick();
        logic hit;
        hit = 1'b0;
        while (!hit) begin
            @(posedge clk);
            hit = os_tick;
        end
        #1;
    endtask

    task automatic bit_cell(input logic v, input int flip_at);
        for (int j = 0; j < 16; j++) begin
            serial_in = (j == flip_at) ? ~v : v;
            wait_tick();
        end
    endtask

    task automatic idle(input int n);
        serial_in = 1'b1;
        for (int k = 0; k < n; k++) wait_tick();
    endtask

    task automatic send_frame(input int nb, input int len_code, input logic [8:0] d,
                              input int pm, input bit bad_par, input logic stop_v,
                              input int extra_stops, input int flip_bit,
                              input bit expect_done, input bit scramble,
                              input int abort_bit);
        logic [8:0] dm;
        logic       p;
        logic       keep_two;
        dm = d & 9'((1 << nb) - 1);
        p  = ^dm;
        if (pm == 3) p = ~p;
        if (bad_par) p = ~p;
        data_len = (len_code < 0) ? 3'(nb - 5) : 3'(len_code);
        par_mode = 2'(pm);
        keep_two = two_stop;
        bit_cell(1'b0, -1);
        if (scramble) begin
            data_len = 3'd0;
            par_mode = (pm >= 2) ? 2'd0 : 2'd2;
            two_stop = ~two_stop;
        end
        for (int b = 0; b < nb; b++) begin
            if (b == abort_bit) rx_en = 1'b0;
            bit_cell(dm[b], (b == flip_bit) ? 8 : -1);
            if (b == abort_bit) rx_en = 1'b1;
        end
        if (pm >= 2) bit_cell(p, -1);
        for (int j = 0; j < 16; j++) begin
            serial_in = stop_v;
            wait_tick();
            if (j == 9 && expect_done) begin
                exp_full = 1'b1;
                exp_data = dm;
                exp_fe   = ~stop_v;
                exp_pe   = (pm >= 2) && bad_par;
            end
        end
        for (int s = 0; s < extra_stops; s++) bit_cell(1'b1, -1);
        two_stop = keep_two;
    endtask

    task automatic do_read();
        serial_in = 1'b1;
        rd_stb = 1'b1;
        @(posedge clk);
        #1;
        rd_stb   = 1'b0;
        exp_full = 1'b0;
        exp_fe   = 1'b0;
        exp_pe   = 1'b0;
        wait_tick();
    endtask

    task automatic check_char(input string tag, input logic [8:0] d,
                              input logic fe, input logic pe);
        chk({tag, " full"}, int'(rx_full), 1);
        chk({tag, " data"}, int'(rx_data), int'(d));
        chk({tag, " frame_err"}, int'(frame_err), int'(fe));
        chk({tag, " parity_err"}, int'(parity_err), int'(pe));
    endtask

    task automatic report();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #600000;
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        chk("R1 rx_full", int'(rx_full), 0);
        chk("R1 rx_data", int'(rx_data), 0);
        chk("R1 frame_err", int'(frame_err), 0);
        chk("R1 parity_err", int'(parity_err), 0);
        rx_en = 1'b1;
        wait_tick();
        idle(20);

        // R2 eight data bits
        send_frame(8, -1, 9'h0A5, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R2 8bit", 9'h0A5, 0, 0);
        do_read();
        // R7 read clears flags, data kept (R13)
        chk("R7 full after read", int'(rx_full), 0);
        chk("R13 data after read", int'(rx_data), 9'h0A5);
        idle(8);

        // R2 five bits, upper bits zero
        send_frame(5, -1, 9'h1F6, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R2 5bit", 9'h016, 0, 0);
        do_read(); idle(8);

        // R2 nine bits and code 7 also nine bits
        send_frame(9, -1, 9'h1C3, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R2 9bit", 9'h1C3, 0, 0);
        do_read(); idle(8);
        send_frame(9, 7, 9'h12D, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R2 code7", 9'h12D, 0, 0);
        do_read(); idle(8);

        // R3 parity modes
        send_frame(7, -1, 9'h05B, 2, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R3 even ok", 9'h05B, 0, 0);
        do_read(); idle(8);
        send_frame(7, -1, 9'h05B, 2, 1, 1'b1, 0, -1, 1, 0, -1);
        check_char("R3 even bad", 9'h05B, 0, 1);
        do_read(); idle(8);
        send_frame(8, -1, 9'h03C, 3, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R3 odd ok", 9'h03C, 0, 0);
        do_read(); idle(8);
        send_frame(8, -1, 9'h03C, 3, 1, 1'b1, 0, -1, 1, 0, -1);
        check_char("R3 odd bad", 9'h03C, 0, 1);
        do_read(); idle(8);
        send_frame(6, -1, 9'h02A, 1, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R3 mode01 none", 9'h02A, 0, 0);
        do_read(); idle(8);

        // R4 low first stop bit
        send_frame(8, -1, 9'h0E7, 2, 0, 1'b0, 0, -1, 1, 0, -1);
        check_char("R4 stop low", 9'h0E7, 1, 0);
        idle(24);
        do_read(); idle(8);

        // R5 two stop bits configured, next start right after first stop
        two_stop = 1'b1;
        send_frame(8, -1, 9'h055, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R5 first", 9'h055, 0, 0);
        send_frame(8, -1, 9'h0C9, 0, 0, 1'b1, 1, -1, 1, 0, -1);
        check_char("R5 back to back", 9'h0C9, 0, 0);
        two_stop = 1'b0;
        do_read(); idle(8);

        // R8 one disagreeing sample at tick 8
        send_frame(8, -1, 9'h000, 0, 0, 1'b1, 0, 3, 1, 0, -1);
        check_char("R8 zero bit", 9'h000, 0, 0);
        do_read(); idle(8);
        send_frame(8, -1, 9'h0FF, 0, 0, 1'b1, 0, 6, 1, 0, -1);
        check_char("R8 one bit", 9'h0FF, 0, 0);
        do_read(); idle(8);

        // R9 short low pulse is discarded
        serial_in = 1'b0;
        for (int k = 0; k < 5; k++) wait_tick();
        idle(30);
        chk("R9 glitch no char", int'(rx_full), 0);
        send_frame(8, -1, 9'h09E, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R9 after glitch", 9'h09E, 0, 0);
        do_read(); idle(8);

        // R10 disabled receiver ignores a frame
        rx_en = 1'b0;
        send_frame(8, -1, 9'h011, 0, 0, 1'b1, 0, -1, 0, 0, -1);
        rx_en = 1'b1;
        idle(8);
        chk("R10 disabled no char", int'(rx_full), 0);
        chk("R10 disabled data kept", int'(rx_data), 9'h09E);
        // R10 abort mid-frame keeps the held character
        send_frame(8, -1, 9'h033, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        send_frame(8, -1, 9'h0FF, 0, 0, 1'b1, 0, -1, 0, 0, 2);
        idle(8);
        check_char("R10 abort held", 9'h033, 0, 0);

        // R11 overwrite of an unread character, error then clean
        send_frame(8, -1, 9'h071, 0, 0, 1'b0, 0, -1, 1, 0, -1);
        idle(24);
        check_char("R11 error char", 9'h071, 1, 0);
        send_frame(8, -1, 9'h05A, 0, 0, 1'b1, 0, -1, 1, 0, -1);
        check_char("R11 overwrite", 9'h05A, 0, 0);
        do_read(); idle(8);

        // R12 format inputs changed after the start bit
        send_frame(8, -1, 9'h081, 2, 0, 1'b1, 0, -1, 1, 1, -1);
        check_char("R12 frozen format", 9'h081, 0, 0);
        do_read(); idle(8);

        report();
    end

endmodule